// File: doc/BRIEF.md
# Prioritized Timer Interrupt Vector Generator

This block collects the pending flags of a timer's capture/compare channels 1 to 6 and its overflow event. Each source has its own enable. It presents a registered, read-only vector word that names the highest-priority source that is both pending and enabled. The word is an even number, so an interrupt handler can add it straight to its program counter and land in a jump table of two-byte entries. A zero word means nothing is pending, and that table slot returns at once.

Reading the vector word clears only the flag of the source that the word reported. Every other pending flag stays set, so the next read reports the next source. A handler can loop back to the read until it gets zero. One shared request line is driven while any enabled source in the shared group is pending.

Channel 0 does not go through the vector. It has its own request line, and its flag clears when that request is acknowledged. The flag-set pulses come from the channel logic, and the read strobe comes from the bus decoder. Both the channel logic and the bus decoder lie outside this block.

Top module: `irqv_top`

## Requirements
- R1: A synchronous active-high reset clears all flags and all enables. In the cycle after reset, `vec_out` is 0, `irq_out` is 0 and `ch0_irq` is 0.
- R2: When no enabled source in the shared group is pending, `vec_out` is 0.
- R3: The vector encodes channel k (1 to 6) as 2·k and the overflow source as 14. When several sources are pending, the lowest channel number wins and overflow has the lowest priority.
- R4: A set flag whose enable bit is 0 is not reported and is not cleared. Once its enable is written to 1, the flag is reported on the next cycle.
- R5: A cycle with `vec_rd` high clears only the flag named by the `vec_out` value present in that cycle. The remaining pending sources are reported one cycle later.
- R6: If a set pulse and a clear (by vector read or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_out` is 1 exactly when `vec_out` is nonzero. It uses the same registered timing as `vec_out`.
- R8: Channel 0 is set through bit 0 of `set_in` and enabled through bit 0 of the enable word. It raises `ch0_irq` and never affects `vec_out`. A `ch0_ack` pulse clears it.
- R9: A vector read while `vec_out` is 0 clears no flag.
- R10: Source bit layout, used by `set_in` and `en_wdata`: bit 0 is channel 0, bits 1 to 6 are channels 1 to 6, and bit 7 is overflow. An input applied before a rising edge shows on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_in | input | 8 | One-cycle set pulses, one per source (layout in R10) |
| en_we | input | 1 | Write strobe for the enable word |
| en_wdata | input | 8 | New enable word (layout in R10) |
| vec_rd | input | 1 | Read strobe for the vector word; clears the reported flag |
| ch0_ack | input | 1 | Acknowledge of the channel 0 request; clears its flag |
| vec_out | output | 4 | Registered vector word: 0, 2, 4 ... 14 |
| irq_out | output | 1 | Shared request for channels 1 to 6 and overflow |
| ch0_irq | output | 1 | Channel 0 request |

## Verification
The bench drains all seven shared sources with back-to-back reads and expects the exact sequence 2 through 14 and then 0. A design whose priority order was wrong would break that sequence. So would a design that cleared more than the reported flag, or that reported a stale value for one cycle after a read. It also reads while a new set pulse hits the reported flag and expects the flag to survive. A design where the clear won would lose the event, and the bench would see the vector move on. Finally, it checks three more cases: a flag that stays pending while its enable is low must reappear once it is enabled, a read at vector 0 must clear nothing, and channel 0 must leave the vector untouched and must survive a set that coincides with its acknowledge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  function automatic int unsigned vec_width(input int unsigned nch);
    return $clog2(2 * (nch + 1) + 1);
  endfunction
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] flag_q,
  output logic [NB-1:0] flag_d
);
  for (genvar i = 0; i < NB; i++) begin : g_flag
    always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]);
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/irqv_enable_reg.sv
module irqv_enable_reg #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] en_q,
  output logic [NB-1:0] en_d
);
  always_comb en_d = we ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  p_en_write_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (en_q == $past(wdata)));
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int NB = 8,
  parameter int VW = 4
) (
  input  logic [NB-1:0] mask_i,
  output logic [VW-1:0] vec_o,
  output logic          any_o
);
  always_comb begin
    vec_o = '0;
    for (int i = NB - 1; i >= 1; i--) begin
      if (mask_i[i]) vec_o = VW'(2 * i);
    end
    any_o = |mask_i[NB-1:1];
  end
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int NCH = 6,
  localparam int NB = NCH + 2,
  localparam int VW = irqv_pkg::vec_width(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_in,
  input  logic          en_we,
  input  logic [NB-1:0] en_wdata,
  input  logic          vec_rd,
  input  logic          ch0_ack,
  output logic [VW-1:0] vec_out,
  output logic          irq_out,
  output logic          ch0_irq
);
  logic [NB-1:0] flag_q, flag_d, en_q, en_d, clr, live;
  logic [VW-1:0] vec_d;
  logic          any_d;

  always_comb begin
    clr = '0;
    for (int i = 1; i < NB; i++) begin
      if (vec_rd && vec_out == VW'(2 * i)) clr[i] = 1'b1;
    end
    clr[0] = ch0_ack;
  end

  irqv_flag_bank #(.NB(NB)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_in), .clr_i(clr),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  irqv_enable_reg #(.NB(NB)) u_en (
    .clk(clk), .rst(rst), .we(en_we), .wdata(en_wdata),
    .en_q(en_q), .en_d(en_d)
  );

  always_comb live = flag_d & en_d;

  irqv_prio_enc #(.NB(NB), .VW(VW)) u_enc (
    .mask_i(live), .vec_o(vec_d), .any_o(any_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_out <= '0;
      irq_out <= 1'b0;
      ch0_irq <= 1'b0;
    end else begin
      vec_out <= vec_d;
      irq_out <= any_d;
      ch0_irq <= live[0];
    end
  end

  p_even_r3: assert property (@(posedge clk) disable iff (rst)
    !vec_out[0] && (vec_out <= VW'(2 * (NB - 1))));
  p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
    irq_out == (vec_out != '0));
  p_one_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr[NB-1:1]));
  p_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && vec_out == '0 && set_in == '0 && !ch0_ack) |=> $stable(flag_q));
  p_ch0_r8: assert property (@(posedge clk) disable iff (rst)
    ch0_irq |-> (flag_q[0] && en_q[0]));
endmodule

// File: tb/irqv_top_test.sv
module irqv_top_test;
  localparam int NB = 8;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] set_in = '0;
  logic          en_we = 1'b0;
  logic [NB-1:0] en_wdata = '0;
  logic          vec_rd = 1'b0;
  logic          ch0_ack = 1'b0;
  logic [VW-1:0] vec_out;
  logic          irq_out, ch0_irq;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [VW-1:0] vec;
    logic          irq;
    logic          c0;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [NB-1:0] m_flag = '0;
  logic [NB-1:0] m_en = '0;

  always #2.5 clk = ~clk;

  irqv_top uut (
    .clk(clk), .rst(rst), .set_in(set_in), .en_we(en_we), .en_wdata(en_wdata),
    .vec_rd(vec_rd), .ch0_ack(ch0_ack), .vec_out(vec_out), .irq_out(irq_out),
    .ch0_irq(ch0_irq)
  );

  function automatic logic [VW-1:0] m_vec(input logic [NB-1:0] f, input logic [NB-1:0] e);
    logic [VW-1:0] v = '0;
    for (int i = NB - 1; i >= 1; i--) if (f[i] && e[i]) v = VW'(2 * i);
    return v;
  endfunction

  task automatic cyc(input logic [NB-1:0] s, input logic rd, input logic ack,
                     input logic we, input logic [NB-1:0] wd, input string tag);
    logic [VW-1:0] cur;
    logic [NB-1:0] c;
    exp_t e;
    @(negedge clk);
    set_in = s; vec_rd = rd; ch0_ack = ack; en_we = we; en_wdata = wd;
    cur = m_vec(m_flag, m_en);
    c = '0;
    if (rd && cur != 0) c[cur >> 1] = 1'b1;
    if (ack) c[0] = 1'b1;
    m_flag = s | (m_flag & ~c);
    if (we) m_en = wd;
    e.vec = m_vec(m_flag, m_en);
    e.irq = (e.vec != 0);
    e.c0 = m_flag[0] & m_en[0];
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        total++;
        if (vec_out !== e.vec || irq_out !== e.irq || ch0_irq !== e.c0) begin
          bad++;
          $display("FAIL %s: vec/irq/ch0 actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
                   e.tag, vec_out, irq_out, ch0_irq, e.vec, e.irq, e.c0);
        end
      end
    end
  end

  initial begin : watchdog
    #500000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    total++;
    if (vec_out !== 0 || irq_out !== 0 || ch0_irq !== 0) begin
      bad++;
      $display("FAIL R1: reset outputs actual=%0d/%0b/%0b expected=0/0/0",
               vec_out, irq_out, ch0_irq);
    end
    // R4, R2: all flags pending but nothing enabled
    cyc(8'hFF, 0, 0, 0, 8'h00, "R4 disabled pending hidden");
    cyc(8'h00, 1, 0, 0, 8'h00, "R9 read at zero");
    // R4: enable everything; R8 ch0 raised separately
    cyc(8'h00, 0, 0, 1, 8'hFF, "R4 enable reveals");
    // R3, R5: drain shared sources in priority order
    for (int k = 0; k < 7; k++) cyc(8'h00, 1, 0, 0, 8'h00, "R3 R5 drain order");
    cyc(8'h00, 1, 0, 0, 8'h00, "R9 read at zero keeps ch0");
    cyc(8'h00, 0, 1, 0, 8'h00, "R8 ack clears ch0");
    // R6: set and read hit the same flag
    cyc(8'h24, 0, 0, 0, 8'h00, "R3 ch2 over ch5");
    cyc(8'h04, 1, 0, 0, 8'h00, "R6 set beats read clear");
    // R4: disable ch2, flag kept, re-enable
    cyc(8'h00, 0, 0, 1, 8'hFB, "R4 disable ch2");
    cyc(8'h00, 0, 0, 1, 8'hFF, "R4 re-enable ch2");
    cyc(8'h00, 1, 0, 0, 8'h00, "R5 read ch2 leaves ch5");
    cyc(8'h00, 1, 0, 0, 8'h00, "R5 read ch5");
    // R8: ch0 set and ack together
    cyc(8'h01, 0, 0, 0, 8'h00, "R8 ch0 set no vector");
    cyc(8'h01, 0, 1, 0, 8'h00, "R8 R6 set beats ack");
    cyc(8'h00, 0, 1, 0, 8'h00, "R8 ack clears");
    // R7, R10: overflow only, lowest priority
    cyc(8'h80, 0, 0, 0, 8'h00, "R7 R10 overflow");
    cyc(8'h02, 0, 0, 0, 8'h00, "R3 ch1 preempts overflow");
    cyc(8'h00, 1, 0, 0, 8'h00, "R5 overflow remains");
    cyc(8'h00, 1, 0, 0, 8'h00, "R7 idle after drain");
    cyc(8'h00, 0, 0, 0, 8'h00, "R2 idle");
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule